// File: doc/BRIEF.md
# Load/Store Bus Interface Unit

This block is the memory access stage of one execution unit. The core hands it one load or store at a time: a 16-bit effective address, a direction flag and, for stores, a 32-bit value. The unit classes the address as internal when it falls inside a local word memory of 2^MEM_AW words, and as external otherwise. For one cycle it publishes the access on a 32-bit status word and a 32-bit write-data word, so that hardware outside the unit can watch or intercept it.

External hardware answers through a 32-bit bus-state word and a 32-bit data input. One bit of the bus state stretches the access by inserting wait cycles, and the unit reports each of these to the core as a stall. Another bit replaces the local memory value with the data input on a read. Loads read the local memory with the address wrapped into its range, whatever the class. Stores change the local memory only when the address is inside that range. Each access takes two cycles when no wait cycles are inserted.

Top module: `bus_iface_unit`

## Requirements
- R1: The status word `bus_addr_o` always has bit 29 set and bits 31:30 and 28:20 clear. When no access is in progress it equals 0x2000_0000.
- R2: During the access cycle, bits 15:0 of the status word carry the request address, and exactly one of these bits is set: 19 for an external read, 18 for an internal read, 17 for an external write, 16 for an internal write.
- R3: An access is internal exactly when its address is below 2^MEM_AW (2048 with the default MEM_AW of 11). Address 2^MEM_AW-1 is internal and address 2^MEM_AW is external.
- R4: A request seen with `req_valid` high while idle appears on the status word in the next cycle. For a load, `rd_valid_o` pulses one cycle after the final access cycle, with the data on `rd_data_o`, which holds that value until the next load completes.
- R5: A load without valid external data returns local word (address mod 2^MEM_AW), for internal and external addresses alike.
- R6: A store to an address at or above 2^MEM_AW leaves the local memory unchanged. A store below it writes the word.
- R7: While bus-state bit 0 is high during an access, `stall_o` is high, the status and data outputs hold their values, and the access does not complete.
- R8: In the final cycle of a load, if bus-state bit 3 is set, the load returns `bus_data_i` instead of the local word.
- R9: Bus-state bit 3 has no effect on a store. An all-zero bus-state word means no wait and no valid data.
- R10: `bus_data_o` equals the store data while a store is on the bus and is zero at all other times.
- R11: A request presented while an access is in progress is ignored.
- R12: After reset the unit is idle, `stall_o` and `rd_valid_o` are low and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request from the core |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Effective address |
| req_wdata | input | 32 | Store data |
| bus_addr_o | output | 32 | Status word: sentinel, class bits, address |
| bus_data_o | output | 32 | Store data on the bus, zero otherwise |
| bus_state_i | input | 32 | Bit 0 wait request, bit 3 data-input valid |
| bus_data_i | input | 32 | Data from external hardware |
| stall_o | output | 1 | Core must hold while high |
| rd_valid_o | output | 1 | One-cycle pulse when load data is ready |
| rd_data_o | output | 32 | Last load result |

## Verification
The assertions check on every cycle the shape of the status word: the fixed sentinel and zero fields, at most one class bit set, and no internal class bit for an address outside the memory. They also check that a stall freezes the status word and that a load result appears only after a read cycle that carried no wait. The wrap of load addresses, the suppression of out-of-range stores, the choice between external data and the local word, and the dropping of requests during an access are all matters of stored content. Only the bench's scenarios can show them, by writing a word and reading it back through an alias address.

// File: rtl/bif_pkg.sv
package bif_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;

    // status word bit positions (decoded by external hardware)
    localparam int SENT_BIT = 29;
    localparam int XRD_BIT  = 19;
    localparam int IRD_BIT  = 18;
    localparam int XWR_BIT  = 17;
    localparam int IWR_BIT  = 16;

    // bus-state bit positions
    localparam int WAIT_BIT = 0;
    localparam int VLD_BIT  = 3;

    localparam logic [DATA_W-1:0] IDLE_WORD = DATA_W'(1) << SENT_BIT;

    typedef struct packed {
        logic              busy;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } ctrl_state_t;
endpackage

// File: rtl/bif_addr_class.sv
module bif_addr_class
    import bif_pkg::*;
#(
    parameter int MEM_AW = 11
) (
    input  logic              busy,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [DATA_W-1:0] status_word
);
    always_comb begin
        in_range    = (addr[ADDR_W-1:MEM_AW] == '0);
        status_word = IDLE_WORD;
        if (busy) begin
            status_word[ADDR_W-1:0] = addr;
            if (write) begin
                if (in_range) status_word[IWR_BIT] = 1'b1;
                else          status_word[XWR_BIT] = 1'b1;
            end else begin
                if (in_range) status_word[IRD_BIT] = 1'b1;
                else          status_word[XRD_BIT] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bif_word_mem.sv
module bif_word_mem
    import bif_pkg::*;
#(
    parameter int MEM_AW = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << MEM_AW;

    logic [DATA_W-1:0] store_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) store_q[idx] <= wdata;
    end

    assign rdata = store_q[idx];
endmodule

// File: rtl/bif_access_ctrl.sv
module bif_access_ctrl
    import bif_pkg::*;
#(
    parameter int MEM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wait_req,
    input  logic              ext_valid,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              in_range,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              write,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              mem_we,
    output logic              stall,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    ctrl_state_t st_d, st_q;
    logic        finish;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        finish        = st_q.busy && !wait_req;
        mem_we        = finish && st_q.write && in_range;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy  = 1'b1;
                st_d.write = req_write;
                st_d.addr  = req_addr;
                st_d.wdata = req_wdata;
            end
        end else if (finish) begin
            st_d.busy = 1'b0;
            if (!st_q.write) begin
                st_d.rd_valid = 1'b1;
                st_d.rd_data  = ext_valid ? ext_data : mem_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign write     = st_q.write;
    assign addr      = st_q.addr;
    assign bus_wdata = (st_q.busy && st_q.write) ? st_q.wdata : '0;
    assign stall     = st_q.busy && wait_req;
    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;

    logic unused_idx;
    assign unused_idx = ^MEM_AW;
endmodule

// File: rtl/bus_iface_unit.sv
module bus_iface_unit
    import bif_pkg::*;
#(
    parameter int MEM_AW = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] bus_addr_o,
    output logic [31:0] bus_data_o,
    input  logic [31:0] bus_state_i,
    input  logic [31:0] bus_data_i,
    output logic        stall_o,
    output logic        rd_valid_o,
    output logic [31:0] rd_data_o
);
    logic              busy, write, in_range, mem_we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] mem_rdata, bus_wdata;

    bif_access_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wait_req  (bus_state_i[WAIT_BIT]),
        .ext_valid (bus_state_i[VLD_BIT]),
        .ext_data  (bus_data_i),
        .in_range  (in_range),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .write     (write),
        .addr      (addr),
        .bus_wdata (bus_wdata),
        .mem_we    (mem_we),
        .stall     (stall_o),
        .rd_valid  (rd_valid_o),
        .rd_data   (rd_data_o)
    );

    bif_addr_class #(.MEM_AW(MEM_AW)) u_class (
        .busy        (busy),
        .write       (write),
        .addr        (addr),
        .in_range    (in_range),
        .status_word (bus_addr_o)
    );

    bif_word_mem #(.MEM_AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .idx   (addr[MEM_AW-1:0]),
        .wdata (bus_wdata),
        .rdata (mem_rdata)
    );

    assign bus_data_o = bus_wdata;

    logic unused_state;
    assign unused_state = ^{bus_state_i[31:4], bus_state_i[2:1]};
endmodule

// File: rtl/bus_iface_chk.sv
module bus_iface_chk #(
    parameter int MEM_AW = 11
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_addr_o,
    input logic [31:0] bus_state_i,
    input logic        stall_o,
    input logic        rd_valid_o
);
    assert_sentinel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_o[31:30] == 2'b00 && bus_addr_o[29] && bus_addr_o[28:20] == '0);

    assert_class_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_addr_o[19:16]));

    assert_internal_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_o[18] || bus_addr_o[16]) |-> (bus_addr_o[15:MEM_AW] == '0));

    assert_external_out_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_o[19] || bus_addr_o[17]) |-> (bus_addr_o[15:MEM_AW] != '0));

    assert_stall_on_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (bus_state_i[0] && bus_addr_o[19:16] != 4'b0000));

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> $stable(bus_addr_o));

    assert_result_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ($past(bus_addr_o[19] || bus_addr_o[18]) && !$past(bus_state_i[0])));
endmodule

bind bus_iface_unit bus_iface_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_o  (bus_addr_o),
    .bus_state_i (bus_state_i),
    .stall_o     (stall_o),
    .rd_valid_o  (rd_valid_o)
);

// File: tb/tb_bus_iface_unit.sv
module tb_bus_iface_unit;
    localparam int MEM_AW = 11;
    localparam int WORDS  = 1 << MEM_AW;
    localparam logic [31:0] BS_IDLE = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0, bus_state_i = '0, bus_data_i = '0;
    logic [31:0] bus_addr_o, bus_data_o, rd_data_o;
    logic        stall_o, rd_valid_o;

    int vectors = 0, miscompares = 0;

    // reference model state
    bit          m_busy = 0, m_write = 0, m_rdv = 0;
    logic [15:0] m_addr = '0;
    logic [31:0] m_wdata = '0, m_rdata = '0;
    logic [31:0] m_mem [int];

    always #4 clk = ~clk;

    bus_iface_unit #(.MEM_AW(MEM_AW)) dut (.*);

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
            bad = 1;
        end
    endtask

    task automatic step(input string tag);
        logic [31:0] e_addr, e_data;
        bit bad = 0;
        bit inr;
        inr    = m_addr < WORDS;
        e_addr = 32'h2000_0000;
        if (m_busy) begin
            e_addr[15:0] = m_addr;
            e_addr = e_addr | (m_write ? (inr ? 32'h1_0000 : 32'h2_0000)
                                       : (inr ? 32'h4_0000 : 32'h8_0000));
        end
        e_data = (m_busy && m_write) ? m_wdata : 32'h0;
        #2;
        vectors++;
        cmp(tag, "bus_addr_o", bus_addr_o, e_addr, bad);
        cmp(tag, "bus_data_o", bus_data_o, e_data, bad);
        cmp(tag, "stall_o", {31'b0, stall_o}, {31'b0, m_busy && bus_state_i[0]}, bad);
        cmp(tag, "rd_valid_o", {31'b0, rd_valid_o}, {31'b0, m_rdv}, bad);
        cmp(tag, "rd_data_o", rd_data_o, m_rdata, bad);
        if (bad) miscompares++;
        @(posedge clk);
        m_rdv = 0;
        if (m_busy) begin
            if (!bus_state_i[0]) begin
                m_busy = 0;
                if (m_write) begin
                    if (inr) m_mem[m_addr % WORDS] = m_wdata;
                end else begin
                    m_rdv = 1;
                    if (bus_state_i[3]) m_rdata = bus_data_i;
                    else if (m_mem.exists(m_addr % WORDS)) m_rdata = m_mem[m_addr % WORDS];
                    else m_rdata = 32'hxxxx_xxxx;
                end
            end
        end else if (req_valid) begin
            m_busy = 1; m_write = req_write; m_addr = req_addr; m_wdata = req_wdata;
        end
        @(negedge clk);
    endtask

    // one access: request cycle, wait cycles, final cycle, result cycle
    task automatic access(input string tag, input bit wr, input logic [15:0] a, input logic [31:0] d,
                          input int nwait, input bit xvld, input logic [31:0] xdata, input bit keep_req);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        bus_state_i = BS_IDLE; bus_data_i = '0;
        step(tag);
        if (keep_req) begin
            req_addr = a ^ 16'h0001; req_wdata = ~d; req_write = ~wr;
        end else req_valid = 0;
        for (int i = 0; i < nwait; i++) begin
            bus_state_i = BS_IDLE | 32'h1;
            step(tag);
        end
        bus_state_i = xvld ? (BS_IDLE | 32'h8) : BS_IDLE;
        bus_data_i  = xdata;
        step(tag);
        req_valid = 0; bus_state_i = BS_IDLE; bus_data_i = '0;
        step(tag);
    endtask

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        begin : reset_check_R12
            bit bad = 0;
            vectors++;
            cmp("R12", "bus_addr_o", bus_addr_o, 32'h2000_0000, bad);
            cmp("R12", "stall_o", {31'b0, stall_o}, 32'h0, bad);
            cmp("R12", "rd_valid_o", {31'b0, rd_valid_o}, 32'h0, bad);
            cmp("R12", "rd_data_o", rd_data_o, 32'h0, bad);
            if (bad) miscompares++;
        end
        rst_n = 1'b1;
        @(negedge clk);
        step("R1 idle");
        // R10 R2 internal stores, then readback R4
        access("R10 store", 1, 16'h0003, 32'hA5A5_0003, 0, 0, 0, 0);
        access("R10 store", 1, 16'h0005, 32'h1234_5678, 0, 0, 0, 0);
        access("R4 load",   0, 16'h0003, 0, 0, 0, 0, 0);
        // R5 wrap of external read
        access("R5 wrap",   0, 16'h0805, 0, 0, 0, 0, 0);
        // R6 out-of-range store must not alias into word 3
        access("R6 ext store", 1, 16'h0803, 32'hDEAD_BEEF, 0, 0, 0, 0);
        access("R6 readback",  0, 16'h0003, 0, 0, 0, 0, 0);
        // R3 boundaries
        access("R3 top internal", 1, 16'(WORDS-1), 32'h7FF7_7FF7, 0, 0, 0, 0);
        access("R3 first external", 0, 16'(WORDS), 32'h0, 0, 0, 0, 0);
        access("R5 0xFFFF wraps", 0, 16'hFFFF, 0, 0, 0, 0, 0);
        // R8 external data overrides
        access("R8 ext valid", 0, 16'h9000, 0, 0, 1, 32'hCAFE_F00D, 0);
        access("R8 int valid", 0, 16'h0005, 0, 0, 1, 32'h0BAD_CAFE, 0);
        // R9 valid bit ignored on store
        access("R9 store vld", 1, 16'h0010, 32'h0000_1010, 0, 1, 32'hFFFF_FFFF, 0);
        access("R9 readback",  0, 16'h0010, 0, 0, 0, 0, 0);
        // R7 wait cycles on load and store
        access("R7 load wait",  0, 16'h0003, 0, 3, 0, 0, 0);
        access("R7 store wait", 1, 16'h0020, 32'h2020_2020, 2, 0, 0, 0);
        access("R7 readback",   0, 16'h0020, 0, 0, 0, 0, 0);
        // R11 request held during access ignored
        access("R11 busy req", 1, 16'h0030, 32'h3030_3030, 1, 0, 0, 1);
        access("R11 readback", 0, 16'h0031, 32'h0, 0, 1, 32'h5555_AAAA, 0);
        access("R11 readback", 0, 16'h0030, 0, 0, 0, 0, 0);
        // R9 all-zero bus state acts as no wait
        req_valid = 1; req_write = 0; req_addr = 16'h0005; bus_state_i = '0;
        step("R9 zero state");
        req_valid = 0;
        step("R9 zero state");
        step("R9 zero state");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule